// File: doc/BRIEF.md
# Banked Video Window to Planar Memory Mapper

This block sits between a host bus and a 32-bit wide video memory that holds four byte planes side by side (plane N in byte lane N of every word). The host sees a 64 KiB window; each host byte access is widened with a bank register into a full byte address, then turned into a word address, lane enables and data for the video memory according to one of three addressing schemes. In chain-4 the byte address walks all planes in turn. In odd/even (text) mapping, even and odd host bytes land in alternate planes. In planar mode every host address names a whole word of four planes, and a read captures that word in a 32-bit latch.

The address check happens after the scheme-specific address has been formed, on every access. Changing the addressing scheme after the bank register has been loaded therefore cannot push an access past the end of memory. Reads that would fall outside return 0xFF and leave both memory and the latch alone. Writes that would fall outside are discarded.

Requests are taken on a valid/ready handshake. Memory is accessed in the accept cycle, and read data appears one cycle later.

Top module: `vga_mem_mapper`

## Requirements
- R1: Writing the bank register stores the written value ANDed with the BANK_MASK parameter, whatever the addressing scheme. The full byte address is the stored bank value concatenated above the 16-bit window offset, so the bank adds bank<<16.
- R2: With seq_chain4 = 1, the full address A is used directly. The memory word is A>>2, the byte lane is A[1:0], and a read returns that lane of the word.
- R3: A chain-4 write updates only lane A[1:0], and only if seq_plane_we bit A[1:0] is 1. Otherwise no memory write occurs.
- R4: With seq_chain4 = 0 and gfx_oddeven = 1, the plane is {gfx_read_plane[1], A[0]}. The memory byte address is {A[top:1], plane}, which equals ((A with bit 0 cleared) << 1) OR plane. A read returns that byte.
- R5: An odd/even write updates only the computed plane's lane, and only if that plane's bit in seq_plane_we is 1. Otherwise no memory write occurs.
- R6: With seq_chain4 = 0 and gfx_oddeven = 0 (planar), word A is read, and the whole 32-bit word is loaded into host_latch in the cycle the read is accepted.
- R7: A planar write presents host_wdata replicated in all four lanes with lane enables equal to seq_plane_we. The stored word is (old AND NOT mask) OR (new AND mask), where mask is seq_plane_we expanded to bytes.
- R8: A planar read with gfx_read_mode = 0 returns lane gfx_read_plane of the word just read. With gfx_read_mode = 1 it returns 0x00.
- R9: If the final byte address (4*A in planar mode) is at or above MEM_BYTES, a read returns 0xFF, issues no memory access and leaves host_latch unchanged.
- R10: An out-of-range write issues no memory access, and memory keeps its old contents.
- R11: host_ready rises after reset is released. An accepted request drives the memory port in the same cycle, and host_rvalid is 1 with the read data exactly one cycle after a read is accepted.
- R12: After reset, host_rvalid = 0, host_rdata = 0x00, host_latch = 0 and the bank value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_offset | input | 16 | Byte offset inside the 64 KiB window |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid |
| host_latch | output | 32 | Word captured by the last in-range planar read |
| bank_wr | input | 1 | Load the bank register |
| bank_wdata | input | BANK_W | New bank value before masking |
| seq_chain4 | input | 1 | Chain-4 addressing select |
| seq_plane_we | input | 4 | Per-plane write enable |
| gfx_oddeven | input | 1 | Odd/even addressing select |
| gfx_read_mode | input | 1 | Planar read mode (0 or 1) |
| gfx_read_plane | input | 2 | Read plane select |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | WORD_W | Memory word address |
| mem_be | output | 4 | Byte-lane (plane) enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle as mem_addr |

## Verification
The bound checker watches every cycle for the following. The memory port may only move while a request is being accepted, and the write lanes must stay inside the plane write-enable mask. Chain-4 and odd/even writes must touch a single lane. A read must answer exactly one cycle after it is taken. A read that causes no memory access must return 0xFF. The latch may change only after a memory read, and a stored bank value may never carry bits outside the mask. Whether the right word and lane were picked is left to the bench's scenarios, which observe the memory contents and returned bytes. The same goes for the bank offset and for the mode-switch case, where a window offset is valid in chain-4 but out of range in planar mode.

// File: rtl/vga_mm_pkg.sv
package vga_mm_pkg;

  typedef enum logic [1:0] {
    AM_CHAIN4  = 2'd0,
    AM_ODDEVEN = 2'd1,
    AM_PLANAR  = 2'd2
  } acc_mode_e;

  function automatic logic [7:0] pick_lane(input logic [31:0] word, input logic [1:0] lane);
    return word[lane*8 +: 8];
  endfunction

endpackage

// File: rtl/vga_mm_bank.sv
module vga_mm_bank #(
  parameter int               BANK_W    = 8,
  parameter logic [BANK_W-1:0] BANK_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);

  logic [BANK_W-1:0] bank_d;
  logic [BANK_W-1:0] bank_r;

  // Mask applies identically in every addressing scheme.
  always_comb begin
    bank_d = bank_r;
    if (wr) bank_d = wdata & BANK_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bank_r <= '0;
    else if (wr) bank_r <= bank_d;
  end

  assign bank = bank_r;

endmodule

// File: rtl/vga_mm_decode.sv
module vga_mm_decode
  import vga_mm_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int MEM_BYTES = 262144,
  localparam int ADDR_W   = 16 + BANK_W,
  localparam int EXT_W    = ADDR_W + 2,
  localparam int WORD_W   = $clog2(MEM_BYTES / 4)
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [15:0]       offset,
  input  logic              chain4,
  input  logic              oddeven,
  input  logic [1:0]        rd_plane,
  input  logic [3:0]        plane_we,
  output acc_mode_e         mode,
  output logic [WORD_W-1:0] word_addr,
  output logic [1:0]        lane,
  output logic              in_range,
  output logic [3:0]        wr_be
);

  localparam logic [EXT_W:0] MEM_LIM = (EXT_W + 1)'(MEM_BYTES);

  logic [ADDR_W-1:0] full;
  logic [1:0]        oe_plane;
  logic [EXT_W-1:0]  ext;
  logic [3:0]        be_raw;

  assign full     = {bank, offset};
  assign oe_plane = {rd_plane[1], full[0]};

  always_comb begin
    if (chain4) begin
      mode   = AM_CHAIN4;
      ext    = {2'b00, full};
      be_raw = 4'b0001 << full[1:0];
    end else if (oddeven) begin
      mode   = AM_ODDEVEN;
      ext    = {1'b0, full[ADDR_W-1:1], oe_plane};
      be_raw = 4'b0001 << oe_plane;
    end else begin
      mode   = AM_PLANAR;
      ext    = {full, 2'b00};
      be_raw = 4'b1111;
    end
  end

  // Bounds test on the final byte address of the selected scheme.
  assign in_range  = {1'b0, ext} < MEM_LIM;
  assign word_addr = ext[WORD_W+1:2];
  assign lane      = ext[1:0];
  assign wr_be     = be_raw & plane_we;

endmodule

// File: rtl/vga_mm_resp.sv
module vga_mm_resp
  import vga_mm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_fire,
  input  logic        in_range,
  input  acc_mode_e   mode,
  input  logic        read_mode1,
  input  logic [1:0]  lane,
  input  logic [1:0]  rd_plane,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic [31:0] latch
);

  logic [7:0]  rdata_d, rdata_r;
  logic        rvalid_d, rvalid_r;
  logic [31:0] latch_d, latch_r;
  logic        rdata_en, latch_en;

  always_comb begin
    rvalid_d = rd_fire;
    rdata_en = rd_fire;
    latch_en = rd_fire && in_range && (mode == AM_PLANAR);
    latch_d  = mem_rdata;
    if (!in_range)                 rdata_d = 8'hFF;
    else if (mode != AM_PLANAR)    rdata_d = pick_lane(mem_rdata, lane);
    else if (read_mode1)           rdata_d = 8'h00;
    else                           rdata_d = pick_lane(mem_rdata, rd_plane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_r <= 1'b0;
      rdata_r  <= 8'h00;
      latch_r  <= 32'h0;
    end else begin
      rvalid_r <= rvalid_d;
      if (rdata_en) rdata_r <= rdata_d;
      if (latch_en) latch_r <= latch_d;
    end
  end

  assign rdata  = rdata_r;
  assign rvalid = rvalid_r;
  assign latch  = latch_r;

endmodule

// File: rtl/vga_mem_mapper.sv
module vga_mem_mapper
  import vga_mm_pkg::*;
#(
  parameter int                MEM_BYTES = 262144,
  parameter int                BANK_W    = 8,
  parameter logic [BANK_W-1:0] BANK_MASK = 8'h03,
  localparam int               WORD_W    = $clog2(MEM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [15:0]       host_offset,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  output logic [31:0]       host_latch,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              seq_chain4,
  input  logic [3:0]        seq_plane_we,
  input  logic              gfx_oddeven,
  input  logic              gfx_read_mode,
  input  logic [1:0]        gfx_read_plane,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic ready_d, ready_q;
  assign ready_d = 1'b1;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ready_q <= 1'b0;
    else            ready_q <= ready_d;
  end
  assign host_ready = ready_q;

  logic [BANK_W-1:0] bank_q;
  acc_mode_e         mode;
  logic [WORD_W-1:0] word_addr;
  logic [1:0]        lane;
  logic              in_range;
  logic [3:0]        wr_be;
  logic              fire;

  assign fire = host_valid && ready_q;

  vga_mm_bank #(.BANK_W(BANK_W), .BANK_MASK(BANK_MASK)) u_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (bank_wr),
    .wdata (bank_wdata),
    .bank  (bank_q)
  );

  vga_mm_decode #(.BANK_W(BANK_W), .MEM_BYTES(MEM_BYTES)) u_dec (
    .bank      (bank_q),
    .offset    (host_offset),
    .chain4    (seq_chain4),
    .oddeven   (gfx_oddeven),
    .rd_plane  (gfx_read_plane),
    .plane_we  (seq_plane_we),
    .mode      (mode),
    .word_addr (word_addr),
    .lane      (lane),
    .in_range  (in_range),
    .wr_be     (wr_be)
  );

  vga_mm_resp u_resp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_fire    (fire && !host_we),
    .in_range   (in_range),
    .mode       (mode),
    .read_mode1 (gfx_read_mode),
    .lane       (lane),
    .rd_plane   (gfx_read_plane),
    .mem_rdata  (mem_rdata),
    .rdata      (host_rdata),
    .rvalid     (host_rvalid),
    .latch      (host_latch)
  );

  // Writes with no enabled lane are not issued at all.
  assign mem_en    = fire && in_range && (!host_we || (wr_be != 4'b0000));
  assign mem_we    = host_we;
  assign mem_addr  = word_addr;
  assign mem_be    = host_we ? wr_be : 4'b1111;
  assign mem_wdata = {4{host_wdata}};

endmodule

// File: rtl/vga_mm_checker.sv
module vga_mm_checker #(
  parameter int                BANK_W    = 8,
  parameter logic [BANK_W-1:0] BANK_MASK = 8'h03
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_we,
  input logic              host_rvalid,
  input logic [7:0]        host_rdata,
  input logic [31:0]       host_latch,
  input logic              seq_chain4,
  input logic              gfx_oddeven,
  input logic              gfx_read_mode,
  input logic [3:0]        seq_plane_we,
  input logic              mem_en,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic [BANK_W-1:0] bank_q
);

  AST_MEM_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (host_valid && host_ready)); // R11

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=> host_rvalid); // R11

  AST_WR_LANES_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ((mem_be & ~seq_plane_we) == 4'b0000)); // R7

  AST_SINGLE_LANE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && (seq_chain4 || gfx_oddeven)) |-> $onehot(mem_be)); // R3

  AST_OOR_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we && !mem_en) |=> (host_rdata == 8'hFF)); // R9

  AST_LATCH_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && !mem_we) |=> $stable(host_latch)); // R6

  AST_MODE1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && !seq_chain4 && !gfx_oddeven && gfx_read_mode) |=> (host_rdata == 8'h00)); // R8

  AST_BANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_q & ~BANK_MASK) == '0)); // R1

endmodule

bind vga_mem_mapper vga_mm_checker #(.BANK_W(BANK_W), .BANK_MASK(BANK_MASK)) u_chk (.*);

// File: tb/tb_vga_mem_mapper.sv
module tb_vga_mem_mapper;

  localparam int MEM_BYTES = 4096;
  localparam int BANK_W    = 4;
  localparam logic [3:0] BANK_MASK = 4'b0101;
  localparam int WORD_W    = 10;
  localparam int NWORDS    = MEM_BYTES / 4;

  logic        clk;
  logic        rst_n;
  logic        host_valid, host_we;
  logic        host_ready;
  logic [15:0] host_offset;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_rvalid;
  logic [31:0] host_latch;
  logic        bank_wr;
  logic [3:0]  bank_wdata;
  logic        seq_chain4, gfx_oddeven, gfx_read_mode;
  logic [3:0]  seq_plane_we;
  logic [1:0]  gfx_read_plane;
  logic        mem_en, mem_we;
  logic [WORD_W-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  logic [31:0] tmem [NWORDS];

  vga_mem_mapper #(.MEM_BYTES(MEM_BYTES), .BANK_W(BANK_W), .BANK_MASK(BANK_MASK)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_offset(host_offset), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_latch(host_latch),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .seq_chain4(seq_chain4), .seq_plane_we(seq_plane_we), .gfx_oddeven(gfx_oddeven),
    .gfx_read_mode(gfx_read_mode), .gfx_read_plane(gfx_read_plane),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: combinational read, byte-lane write at the clock edge.
  assign mem_rdata = tmem[mem_addr];
  always @(posedge clk) begin
    if (mem_en) acc_cnt <= acc_cnt + 1;
    if (mem_en && mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) tmem[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
  end

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {b ^ 8'h5A, b ^ 8'hC3, b + 8'h11, b};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic c4, input logic oe, input logic rm, input logic [1:0] rp, input logic [3:0] we);
    @(negedge clk);
    seq_chain4 = c4; gfx_oddeven = oe; gfx_read_mode = rm; gfx_read_plane = rp; seq_plane_we = we;
  endtask

  task automatic host_read(input logic [15:0] off, output logic [7:0] data, output int accesses, output logic valid);
    int a0;
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_offset = off;
    a0 = acc_cnt;
    @(negedge clk);
    host_valid = 1'b0;
    data = host_rdata; valid = host_rvalid; accesses = acc_cnt - a0;
  endtask

  task automatic host_write(input logic [15:0] off, input logic [7:0] d, output int accesses);
    int a0;
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_offset = off; host_wdata = d;
    a0 = acc_cnt;
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    accesses = acc_cnt - a0;
  endtask

  task automatic load_bank(input logic [3:0] v);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = v;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12", "rvalid after reset", {31'b0, host_rvalid}, 32'd0);
    chk("R12", "rdata after reset", {24'b0, host_rdata}, 32'h0);
    chk("R12", "latch after reset", host_latch, 32'h0);
    chk("R11", "ready after reset", {31'b0, host_ready}, 32'd1);
  endtask

  task automatic t_chain4;
    logic [7:0] d; int n; logic v;
    set_mode(1'b1, 1'b0, 1'b0, 2'd0, 4'b0010);
    host_read(16'h0123, d, n, v);                      // word 0x48 lane 3
    chk("R2", "chain4 read byte", {24'b0, d}, {24'b0, pat(32'h48)[31:24]});
    chk("R11", "rvalid one cycle after read", {31'b0, v}, 32'd1);
    host_write(16'h0201, 8'h77, n);                    // word 0x80 lane 1, enabled
    chk("R3", "chain4 enabled write", tmem[10'h080], {pat(32'h80)[31:16], 8'h77, pat(32'h80)[7:0]});
    host_write(16'h0202, 8'h99, n);                    // lane 2, disabled
    chk("R3", "chain4 disabled write no access", n, 0);
    chk("R3", "chain4 disabled write word", tmem[10'h080], {pat(32'h80)[31:16], 8'h77, pat(32'h80)[7:0]});
  endtask

  task automatic t_oddeven;
    logic [7:0] d; int n; logic v;
    set_mode(1'b0, 1'b1, 1'b0, 2'b10, 4'b0100);
    host_read(16'h0101, d, n, v);                      // plane 3, byte 0x203 -> word 0x80 lane 3
    chk("R4", "odd/even read byte", {24'b0, d}, {24'b0, pat(32'h80)[31:24]});
    host_write(16'h0300, 8'h5A, n);                    // plane 2, byte 0x602 -> word 0x180 lane 2
    chk("R5", "odd/even enabled write", tmem[10'h180], {pat(32'h180)[31:24], 8'h5A, pat(32'h180)[15:0]});
    set_mode(1'b0, 1'b1, 1'b0, 2'b10, 4'b1011);
    host_write(16'h0310, 8'hEE, n);                    // plane 2 disabled
    chk("R5", "odd/even disabled write no access", n, 0);
    chk("R5", "odd/even disabled write word", tmem[10'h188], pat(32'h188));
    host_read(16'h0800, d, n, v);                      // byte 0x1002 >= 4096
    chk("R9", "odd/even out-of-range read", {24'b0, d}, 32'hFF);
  endtask

  task automatic t_planar;
    logic [7:0] d; int n; logic v;
    set_mode(1'b0, 1'b0, 1'b0, 2'd2, 4'b1001);
    host_read(16'h0010, d, n, v);
    chk("R6", "planar latch load", host_latch, pat(32'h10));
    chk("R8", "read mode 0 plane 2 byte", {24'b0, d}, {24'b0, pat(32'h10)[23:16]});
    host_write(16'h0011, 8'hC3, n);
    chk("R7", "planar masked write", tmem[10'h011], (pat(32'h11) & 32'h00FFFF00) | 32'hC30000C3);
    set_mode(1'b0, 1'b0, 1'b1, 2'd2, 4'b1001);
    host_read(16'h0020, d, n, v);
    chk("R8", "read mode 1 returns zero", {24'b0, d}, 32'h0);
    chk("R6", "latch loaded in mode 1", host_latch, pat(32'h20));
  endtask

  task automatic t_bounds;
    logic [7:0] d; int n; logic v;
    set_mode(1'b0, 1'b0, 1'b0, 2'd0, 4'b1111);
    host_read(16'h0400, d, n, v);                      // 0x400*4 = 4096
    chk("R9", "planar out-of-range read", {24'b0, d}, 32'hFF);
    chk("R9", "no access on out-of-range read", n, 0);
    chk("R9", "latch unchanged on out-of-range read", host_latch, pat(32'h20));
    host_write(16'h0400, 8'h11, n);
    chk("R10", "out-of-range write dropped", n, 0);
    host_read(16'h03FF, d, n, v);                      // last word, in range
    chk("R6", "planar last word latched", host_latch, pat(32'h3FF));
    set_mode(1'b1, 1'b0, 1'b0, 2'd0, 4'b1111);         // same offset now valid
    host_read(16'h0400, d, n, v);
    chk("R2", "chain4 after mode switch", {24'b0, d}, {24'b0, pat(32'h100)[7:0]});
    host_read(16'h1000, d, n, v);
    chk("R9", "chain4 out-of-range read", {24'b0, d}, 32'hFF);
    host_write(16'h1000, 8'h22, n);
    chk("R10", "chain4 out-of-range write dropped", n, 0);
  endtask

  task automatic t_bank;
    logic [7:0] d; int n; logic v;
    set_mode(1'b1, 1'b0, 1'b0, 2'd0, 4'b1111);
    load_bank(4'b1111);                                // masked to 0101 -> base 0x50000
    host_read(16'h0000, d, n, v);
    chk("R1", "masked bank out of range", {24'b0, d}, 32'hFF);
    load_bank(4'b1010);                                // masked to 0000
    host_read(16'h0010, d, n, v);
    chk("R1", "masked-off bank bits ignored", {24'b0, d}, {24'b0, pat(32'h4)[7:0]});
    set_mode(1'b0, 1'b0, 1'b0, 2'd1, 4'b1111);         // same mask in planar mode
    load_bank(4'b1010);
    host_read(16'h0005, d, n, v);
    chk("R1", "bank mask in planar mode", {24'b0, d}, {24'b0, pat(32'h5)[15:8]});
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) tmem[i] = pat(i);
    rst_n = 1'b0; host_valid = 1'b0; host_we = 1'b0; host_offset = '0; host_wdata = '0;
    bank_wr = 1'b0; bank_wdata = '0; seq_chain4 = 1'b0; gfx_oddeven = 1'b0;
    gfx_read_mode = 1'b0; gfx_read_plane = '0; seq_plane_we = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_chain4;
    t_oddeven;
    t_planar;
    t_bounds;
    t_bank;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule